// File: doc/BRIEF.md
# Instruction Fetch and Exception Entry Sequencer

This block is the control core of a small 16-bit processor. It fetches instruction words over a simple read port. It holds the current instruction in a prefetch register and presents it to an external execute unit. It owns the program counter and the status word, and it performs exception entry, trap entry and return-from-exception. The execute unit and the general register file sit outside. They report each instruction's outcome on a set of level inputs qualified by `ex_done`, and they hold that outcome until `retire` pulses.

While an instruction is presented, the sequencer already reads the following word, so a plain step needs no extra bus cycle. A redirect discards the word read ahead. A redirect is any write to the program counter or a return-from-exception. Exception entry saves the return context and clears both interrupt-enable bits of the status word. It then spends one bus read fetching the handler address from a table of words at `vec_base`, indexed by the cause number. Execution resumes with a fresh fetch at that address. The restore of the destination general register on return belongs to the datapath.

Top module: `fes_seq`

## Requirements
- R1: While reset is held, the state is: `pc` equals the reset address parameter (default 0x0040), `sr`, `epc`, `esr` and `ecause` are zero, and `insn_valid` is low. A read request is posted at the reset address.
- R2: In the fetch phase, the block reads the word at `pc`. When that read is acknowledged, the word appears on `insn`, `pc` grows by 2 and `insn_valid` rises.
- R3: While `insn_valid` is high, the word at `pc` is read ahead. A plain step loads that word into `insn` and adds 2 to `pc`, and it needs no further bus read.
- R4: A step with `ex_pc_we` loads `pc` from `ex_pc_wdata` and drops `insn_valid`. It discards the word read ahead, and the next bus read is at the new `pc`.
- R5: On exception entry, `epc` takes the address of the word being read ahead, which equals `pc`. `esr` takes `sr`, `ecause` takes the cause, and bits 1:0 of `sr` (the interrupt enables) are cleared.
- R6: The handler address is read from `vec_base + 2*cause`. It becomes `pc`, and fetching restarts there.
- R7: Cause priority is misaligned access (cause 2) above invalid opcode (cause 3) above trap (cause taken from `ex_trap_cause`).
- R8: A fetch at an odd `pc` issues no bus read. It enters the exception with cause 2 and `epc` equal to that odd address.
- R9: A return step loads `pc` from `epc` and `sr` from `esr`, then refetches.
- R10: Outcome inputs take effect only when `ex_done` is high while `insn_valid` is high. During the fetch phase they change neither `epc`, `ecause` nor `retire`.
- R11: An odd handler address is not faulted during the vector read. The fault is taken on the fetch that follows, with `epc` equal to that handler address.
- R12: A plain step with `ex_sr_we` loads `sr` from `ex_sr_wdata`. On an exception step, `ex_sr_we` is ignored.
- R13: A posted read keeps `mem_req` high and `mem_addr` unchanged until `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | 16 | Byte address of the requested word |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | One-cycle read acknowledge |
| vec_base | input | 16 | Byte address of the handler table |
| insn | output | 16 | Instruction presented to the execute unit |
| insn_valid | output | 1 | `insn` is current (execute phase) |
| retire | output | 1 | Pulses the cycle after a step is committed |
| ex_done | input | 1 | Execute outcome valid |
| ex_pc_we | input | 1 | Instruction writes the program counter |
| ex_pc_wdata | input | 16 | New program counter |
| ex_sr_we | input | 1 | Instruction writes the status word |
| ex_sr_wdata | input | 16 | New status word |
| ex_reti | input | 1 | Return from exception |
| ex_trap | input | 1 | Explicit trap request |
| ex_trap_cause | input | 4 | Cause number of the trap |
| ex_illegal | input | 1 | Invalid opcode detected |
| ex_unaligned | input | 1 | Misaligned data access detected |
| pc | output | 16 | Program counter |
| sr | output | 16 | Status word |
| epc | output | 16 | Saved return address |
| esr | output | 16 | Saved status word |
| ecause | output | 4 | Cause of the last exception entry |

## Verification
The properties assume the following about the read port and the table base. `mem_ack` is a single-cycle pulse that answers a pending request. `vec_base` is even and does not move while a vector read waits. Without these, the held-request and no-odd-read checks could not hold. The bench memory only acknowledges a request that is pending and not already being answered, and it stalls on a pseudo-random pattern. It keeps `vec_base` at a fixed even value. The stand-in execute unit holds every outcome until `retire`, which matches the handshake the commit logic expects.

// File: rtl/fes_pkg.sv
package fes_pkg;

  typedef enum logic [1:0] {
    ST_FETCH  = 2'd0,
    ST_EXEC   = 2'd1,
    ST_VECTOR = 2'd2
  } fes_state_e;

  localparam int CAUSE_MISALIGN = 2;
  localparam int CAUSE_BADOP    = 3;
  localparam int IE_BITS        = 2;

endpackage

// File: rtl/fes_cause_pick.sv
module fes_cause_pick #(
  parameter int CW = 4
) (
  input  logic          misalign,
  input  logic          badop,
  input  logic          trap,
  input  logic [CW-1:0] trap_code,
  output logic          take,
  output logic [CW-1:0] code
);
  import fes_pkg::*;

  // fixed priority: misaligned, then bad opcode, then trap
  always_comb begin
    take = misalign | badop | trap;
    if (misalign)   code = CW'(CAUSE_MISALIGN);
    else if (badop) code = CW'(CAUSE_BADOP);
    else            code = trap_code;
  end

endmodule

// File: rtl/fes_ctx.sv
module fes_ctx #(
  parameter int XLEN = 16,
  parameter int CW   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            save,
  input  logic [XLEN-1:0] pc_in,
  input  logic [XLEN-1:0] sr_in,
  input  logic [CW-1:0]   code_in,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] esr,
  output logic [CW-1:0]   ecause
);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc    <= '0;
      esr    <= '0;
      ecause <= '0;
    end else if (save) begin
      epc    <= pc_in;
      esr    <= sr_in;
      ecause <= code_in;
    end
  end

  AST_CTX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !save |=> ($stable(epc) && $stable(esr) && $stable(ecause))); // R5

endmodule

// File: rtl/fes_rd_port.sv
module fes_rd_port #(
  parameter int              XLEN     = 16,
  parameter logic [XLEN-1:0] RST_ADDR = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_d,
  input  logic [XLEN-1:0] addr_d,
  input  logic            mem_ack,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= ~RST_ADDR[0];
      mem_addr <= RST_ADDR;
    end else begin
      mem_req  <= req_d;
      mem_addr <= addr_d;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R13

endmodule

// File: rtl/fes_seq.sv
module fes_seq #(
  parameter int              XLEN     = 16,
  parameter int              CW       = 4,
  parameter logic [XLEN-1:0] RESET_PC = 16'h0040
) (
  input  logic            clk,
  input  logic            rst,
  output logic            mem_req,
  output logic [XLEN-1:0] mem_addr,
  input  logic [XLEN-1:0] mem_rdata,
  input  logic            mem_ack,
  input  logic [XLEN-1:0] vec_base,
  output logic [XLEN-1:0] insn,
  output logic            insn_valid,
  output logic            retire,
  input  logic            ex_done,
  input  logic            ex_pc_we,
  input  logic [XLEN-1:0] ex_pc_wdata,
  input  logic            ex_sr_we,
  input  logic [XLEN-1:0] ex_sr_wdata,
  input  logic            ex_reti,
  input  logic            ex_trap,
  input  logic [CW-1:0]   ex_trap_cause,
  input  logic            ex_illegal,
  input  logic            ex_unaligned,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] sr,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] esr,
  output logic [CW-1:0]   ecause
);
  import fes_pkg::*;

  localparam int              PAD     = XLEN - CW - 1;
  localparam logic [XLEN-1:0] IE_MASK = XLEN'((1 << IE_BITS) - 1);
  localparam logic [XLEN-1:0] STEP    = XLEN'(2);

  fes_state_e      state, state_d;
  logic [XLEN-1:0] pc_d, sr_d, pf, pf_d, nxt, nxt_d, word_in, addr_d;
  logic            nxt_v, nxt_v_d, retire_d, save, req_d, commit;
  logic            take;
  logic [CW-1:0]   pick_code, save_code, cause_d;

  fes_cause_pick #(.CW(CW)) u_pick (
    .misalign  (ex_unaligned),
    .badop     (ex_illegal),
    .trap      (ex_trap),
    .trap_code (ex_trap_cause),
    .take      (take),
    .code      (pick_code)
  );

  fes_ctx #(.XLEN(XLEN), .CW(CW)) u_ctx (
    .clk     (clk),
    .rst     (rst),
    .save    (save),
    .pc_in   (pc),
    .sr_in   (sr),
    .code_in (save_code),
    .epc     (epc),
    .esr     (esr),
    .ecause  (ecause)
  );

  assign word_in = nxt_v ? nxt : mem_rdata;
  assign commit  = (state == ST_EXEC) && ex_done && (nxt_v || mem_ack);

  always_comb begin
    state_d   = state;
    pc_d      = pc;
    sr_d      = sr;
    pf_d      = pf;
    nxt_d     = nxt;
    nxt_v_d   = nxt_v;
    retire_d  = 1'b0;
    save      = 1'b0;
    save_code = CW'(CAUSE_MISALIGN);
    unique case (state)
      ST_FETCH: begin
        if (pc[0]) begin
          save    = 1'b1;
          sr_d    = sr & ~IE_MASK;
          state_d = ST_VECTOR;
        end else if (mem_ack) begin
          pf_d    = mem_rdata;
          pc_d    = pc + STEP;
          nxt_v_d = 1'b0;
          state_d = ST_EXEC;
        end
      end
      ST_EXEC: begin
        if (mem_ack) begin
          nxt_d   = mem_rdata;
          nxt_v_d = 1'b1;
        end
        if (commit) begin
          retire_d = 1'b1;
          nxt_v_d  = 1'b0;
          if (take) begin
            save      = 1'b1;
            save_code = pick_code;
            sr_d      = sr & ~IE_MASK;
            state_d   = ST_VECTOR;
          end else if (ex_reti) begin
            pc_d    = epc;
            sr_d    = esr;
            state_d = ST_FETCH;
          end else begin
            if (ex_sr_we) sr_d = ex_sr_wdata;
            if (ex_pc_we) begin
              pc_d    = ex_pc_wdata;
              state_d = ST_FETCH;
            end else begin
              pf_d = word_in;
              pc_d = pc + STEP;
            end
          end
        end
      end
      ST_VECTOR: begin
        if (mem_ack) begin
          pc_d    = mem_rdata;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_FETCH;
    endcase
  end

  // next bus request follows the next state
  always_comb begin
    cause_d = save ? save_code : ecause;
    req_d   = ((state_d == ST_FETCH) && !pc_d[0]) ||
              ((state_d == ST_EXEC) && !nxt_v_d) ||
              (state_d == ST_VECTOR);
    addr_d  = (state_d == ST_VECTOR) ?
              (vec_base + {{PAD{1'b0}}, cause_d, 1'b0}) : pc_d;
  end

  fes_rd_port #(.XLEN(XLEN), .RST_ADDR(RESET_PC)) u_port (
    .clk      (clk),
    .rst      (rst),
    .req_d    (req_d),
    .addr_d   (addr_d),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_addr (mem_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_FETCH;
      pc     <= RESET_PC;
      sr     <= '0;
      pf     <= '0;
      nxt    <= '0;
      nxt_v  <= 1'b0;
      retire <= 1'b0;
    end else begin
      state  <= state_d;
      pc     <= pc_d;
      sr     <= sr_d;
      pf     <= pf_d;
      nxt    <= nxt_d;
      nxt_v  <= nxt_v_d;
      retire <= retire_d;
    end
  end

  assign insn       = pf;
  assign insn_valid = (state == ST_EXEC);

  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FETCH && !pc[0] && mem_ack) |=>
      (state == ST_EXEC && pc == $past(pc) + STEP)); // R2
  AST_IE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VECTOR) |-> ((sr & IE_MASK) == '0)); // R5
  AST_VEC_LOAD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VECTOR && mem_ack) |=>
      (state == ST_FETCH && pc == $past(mem_rdata))); // R6
  AST_NO_ODD_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !mem_addr[0]); // R8
  AST_RETIRE_SRC: assert property (@(posedge clk) disable iff (rst)
    retire |-> ($past(state) == ST_EXEC && $past(ex_done))); // R10

endmodule

// File: tb/tb_fes_seq.sv
module tb_fes_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mem_req, mem_ack;
  logic [15:0] mem_addr, mem_rdata;
  logic [15:0] vec_base = 16'h0100;
  logic [15:0] insn, pc, sr, epc, esr;
  logic        insn_valid, retire;
  logic        ex_done = 0, ex_pc_we = 0, ex_sr_we = 0, ex_reti = 0;
  logic        ex_trap = 0, ex_illegal = 0, ex_unaligned = 0;
  logic [15:0] ex_pc_wdata = '0, ex_sr_wdata = '0;
  logic [3:0]  ex_trap_cause = '0, ecause;

  int checks = 0;
  int fails  = 0;
  logic [15:0] exp_q[$];
  logic [7:0]  lfsr;

  fes_seq dut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .vec_base(vec_base),
    .insn(insn), .insn_valid(insn_valid), .retire(retire),
    .ex_done(ex_done), .ex_pc_we(ex_pc_we), .ex_pc_wdata(ex_pc_wdata),
    .ex_sr_we(ex_sr_we), .ex_sr_wdata(ex_sr_wdata), .ex_reti(ex_reti),
    .ex_trap(ex_trap), .ex_trap_cause(ex_trap_cause),
    .ex_illegal(ex_illegal), .ex_unaligned(ex_unaligned),
    .pc(pc), .sr(sr), .epc(epc), .esr(esr), .ecause(ecause)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [15:0] mem_word(input logic [15:0] a);
    case (a)
      16'h0104: return 16'h0080;
      16'h0106: return 16'h0090;
      16'h010A: return 16'h00A1;
      default:  return a ^ 16'h5A00;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic expect_read(input logic [15:0] a);
    exp_q.push_back(a);
  endtask

  // memory model and read monitor (scoreboard consumer)
  always @(posedge clk) begin
    if (rst) begin
      mem_ack   <= 1'b0;
      mem_rdata <= '0;
      lfsr      <= 8'hB5;
    end else begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (mem_req && !mem_ack && (lfsr[0] | lfsr[3])) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem_word(mem_addr);
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6 read order: actual=%h expected=none", mem_addr);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (e !== mem_addr) begin
            fails++;
            $display("FAIL R3/R4/R6 read order: actual=%h expected=%h", mem_addr, e);
          end
        end
      end else begin
        mem_ack <= 1'b0;
      end
    end
  end

  task automatic clear_outcome();
    ex_done = 0; ex_pc_we = 0; ex_sr_we = 0; ex_reti = 0;
    ex_trap = 0; ex_illegal = 0; ex_unaligned = 0;
  endtask

  task automatic wait_retire();
    ex_done = 1;
    @(negedge clk);
    while (!retire) @(negedge clk);
    clear_outcome();
  endtask

  task automatic wait_valid();
    while (!insn_valid) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    foreach (exp_q[i]) exp_q.delete(i);
    expect_read(16'h0040); expect_read(16'h0042); expect_read(16'h0044);
    expect_read(16'h0060); expect_read(16'h0062); expect_read(16'h0106);
    expect_read(16'h0090); expect_read(16'h0092); expect_read(16'h0062);
    expect_read(16'h0064); expect_read(16'h0104); expect_read(16'h0080);
    expect_read(16'h0082); expect_read(16'h010A); expect_read(16'h0104);
    expect_read(16'h0080); expect_read(16'h0082);

    repeat (3) @(negedge clk);
    chk("R1 pc", pc, 16'h0040);
    chk("R1 sr", sr, 16'h0000);
    chk("R1 insn_valid", {15'd0, insn_valid}, 16'd0);
    chk("R1 mem_req", {15'd0, mem_req}, 16'd1);
    chk("R1 mem_addr", mem_addr, 16'h0040);
    rst = 0;

    // R10: outcome presented during fetch must be ignored
    ex_done = 1; ex_illegal = 1; ex_trap = 1; ex_trap_cause = 4'd9;
    while (!mem_ack) begin
      @(negedge clk);
      chk("R10 no retire in fetch", {15'd0, retire}, 16'd0);
    end
    clear_outcome();
    @(negedge clk);
    wait_valid();
    chk("R2 insn", insn, mem_word(16'h0040));
    chk("R2 pc", pc, 16'h0042);
    chk("R10 ecause", {12'd0, ecause}, 16'd0);
    chk("R10 epc", epc, 16'h0000);

    // R3 + R12: plain step with status write
    ex_sr_we = 1; ex_sr_wdata = 16'h00F3;
    wait_retire();
    chk("R3 insn", insn, mem_word(16'h0042));
    chk("R3 pc", pc, 16'h0044);
    chk("R3 insn_valid", {15'd0, insn_valid}, 16'd1);
    chk("R12 sr", sr, 16'h00F3);

    // R4: program counter write
    ex_pc_we = 1; ex_pc_wdata = 16'h0060;
    wait_retire();
    chk("R4 insn_valid drop", {15'd0, insn_valid}, 16'd0);
    chk("R4 pc", pc, 16'h0060);
    wait_valid();
    chk("R4 insn", insn, mem_word(16'h0060));
    chk("R4 pc after", pc, 16'h0062);

    // R5 + R7: invalid opcode beats trap
    ex_illegal = 1; ex_trap = 1; ex_trap_cause = 4'd7;
    wait_retire();
    chk("R5 epc", epc, 16'h0062);
    chk("R5 esr", esr, 16'h00F3);
    chk("R5 sr", sr, 16'h00F0);
    chk("R7 cause 3", {12'd0, ecause}, 16'd3);
    wait_valid();
    chk("R6 pc", pc, 16'h0092);
    chk("R6 insn", insn, mem_word(16'h0090));

    // R9: return from exception
    ex_reti = 1;
    wait_retire();
    chk("R9 pc", pc, 16'h0062);
    chk("R9 sr", sr, 16'h00F3);
    wait_valid();
    chk("R9 insn", insn, mem_word(16'h0062));

    // R7: misaligned beats invalid opcode
    ex_unaligned = 1; ex_illegal = 1;
    wait_retire();
    chk("R7 cause 2", {12'd0, ecause}, 16'd2);
    chk("R5 epc2", epc, 16'h0064);
    chk("R5 esr2", esr, 16'h00F3);
    wait_valid();
    chk("R6 pc2", pc, 16'h0082);

    // R11 + R8 + R12: trap to odd handler, status write ignored
    ex_trap = 1; ex_trap_cause = 4'd5; ex_sr_we = 1; ex_sr_wdata = 16'h1234;
    wait_retire();
    chk("R7 trap cause", {12'd0, ecause}, 16'd5);
    chk("R12 sr ignored", sr, 16'h00F0);
    wait_valid();
    chk("R11 cause", {12'd0, ecause}, 16'd2);
    chk("R8 epc odd", epc, 16'h00A1);
    chk("R8 esr", esr, 16'h00F0);
    chk("R11 pc", pc, 16'h0082);
    chk("R11 insn", insn, mem_word(16'h0080));

    repeat (20) @(negedge clk);
    chk("R6 reads consumed", 16'(exp_q.size()), 16'd0);
    chk("R3 idle pc", pc, 16'h0082);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule